// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Recovery

This block turns a single asynchronous serial input line into characters. A one-clock enable pulse arrives at sixteen times the bit rate. The receiver counts these pulses to find the middle of each bit on the line. A character is a start bit, then five to eight data bits with the least significant bit first, then an optional parity bit that is checked for even or odd parity, then one stop bit. For each character the block raises a one-clock strobe. The strobe carries the data byte and three tags: parity error, framing error and break.

Two kinds of line fault are handled without losing alignment:

- **Bad stop bit.** The receiver assumes the low level it found is the start bit of the next character. It confirms that level once more on the next enable pulse and then samples the data bits of that character on the normal 16-pulse spacing.
- **Break.** The line is low for longer than a whole word. This yields exactly one all-zero character tagged as a break, however long the break lasts. The receiver then stays silent until the line has been high for half a bit time without interruption.

The baud divisor, buffering and any register access sit outside this block.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset, `char_valid`, `char_data`, `char_perr`, `char_ferr` and `char_brk` are all 0.
- R2: A falling edge is taken as a start bit only if the line is still low 8 enable pulses later. A low pulse shorter than that produces no character.
- R3: The data width is set by `cfg_data_bits`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data is received least significant bit first into `char_data[0]` upward. Unused upper bits of `char_data` read 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_odd` = 0 selects even parity and 1 selects odd parity. `char_perr` is 1 exactly when the received parity bit disagrees with the selected parity.
- R5: If the stop bit is sampled low and the character is not a break, the character is delivered with `char_ferr` = 1 and its data intact.
- R6: After a framing error, the low stop bit is treated as the start bit of the next character. That character's data bits are sampled 16, 32, … enable pulses after the bad stop sample, with no new falling edge needed.
- R7: A break is all data bits 0, parity bit (if enabled) 0 and stop bit 0, with the line still low 8 pulses after the stop sample, that is, a full word time. It yields exactly one character with `char_data` = 0, `char_brk` = 1, `char_ferr` = 0 and `char_perr` = 0, however long the line stays low.
- R8: An all-zero character with a low stop bit is reported as a framing error, not a break, if the line rises within 8 pulses of the stop sample.
- R9: After a break, no new start bit is accepted until the line has been high for 8 consecutive enable pulses. A low level inside that window restarts the count.
- R10: `char_valid` is high for exactly one clock per character.
- R11: An all-zero character with a valid high stop bit is an ordinary character with no tags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-clock enable pulse at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input line, idle high |
| cfg_data_bits | input | 2 | Data width select: 00 = 5 bits through 11 = 8 bits |
| cfg_par_en | input | 1 | A parity bit follows the data |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| char_valid | output | 1 | One-clock character strobe |
| char_data | output | DATA_W | Received data, least significant bit first on the line |
| char_perr | output | 1 | Parity error tag |
| char_ferr | output | 1 | Framing error tag |
| char_brk | output | 1 | Break tag |

## Verification
The line passes through a two-flop synchroniser, so every result has a known position in time:

- An ordinary or framing-error character appears one clock after the enable pulse that samples the stop bit's midpoint.
- A break character appears one clock after the eighth pulse beyond that midpoint.

The bench drives the line on falling clock edges, with an enable pulse every four clocks. It captures each strobe on a falling edge, so the result never depends on process order at the active edge. It then lets at least 20 idle pulses pass before comparing the count and fields of the captured characters. For the rejection cases (short start pulse, re-arm window), the bench checks that no character was captured. It then sends a fresh character to show the receiver has returned to idle.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_CONFIRM,
    ST_BRKWAIT,
    ST_REARM
  } rx_state_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par_bit,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              par_err
);

  // Unused upper data bits are held at zero, so reducing the whole word is exact.
  logic expected;
  assign expected = (^data) ^ par_odd;
  assign par_err  = par_en & (par_bit != expected);

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  input  logic [1:0]        cfg_data_bits,
  input  logic              cfg_par_en,
  input  logic              par_err,
  output logic [DATA_W-1:0] shreg,
  output logic              par_bit,
  output logic              char_valid,
  output logic [DATA_W-1:0] char_data,
  output logic              char_perr,
  output logic              char_ferr,
  output logic              char_brk
);

  localparam int SUB_W    = $clog2(OVERSAMPLE);
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int MIN_BITS = DATA_W - 3;
  localparam logic [SUB_W-1:0] MID  = SUB_W'(OVERSAMPLE / 2 - 1);
  localparam logic [SUB_W-1:0] LAST = SUB_W'(OVERSAMPLE - 1);

  rx_state_t         state;
  logic [SUB_W-1:0]  sub;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W-1:0]  last_idx;
  logic              zero_word;

  assign last_idx  = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_data_bits);
  assign zero_word = (shreg == '0) && !(cfg_par_en && par_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sub        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      par_bit    <= 1'b0;
      char_valid <= 1'b0;
      char_data  <= '0;
      char_perr  <= 1'b0;
      char_ferr  <= 1'b0;
      char_brk   <= 1'b0;
    end else begin
      char_valid <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: begin
            if (!rxd) begin
              state <= ST_START;
              sub   <= SUB_W'(1);
            end
          end

          ST_START: begin
            if (sub == MID) begin
              if (!rxd) begin
                state   <= ST_DATA;
                sub     <= '0;
                bit_idx <= '0;
                shreg   <= '0;
                par_bit <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sub <= sub + 1'b1;
            end
          end

          ST_DATA: begin
            if (sub == LAST) begin
              sub            <= '0;
              shreg[bit_idx] <= rxd;
              if (bit_idx == last_idx) state <= cfg_par_en ? ST_PARITY : ST_STOP;
              else                     bit_idx <= bit_idx + 1'b1;
            end else begin
              sub <= sub + 1'b1;
            end
          end

          ST_PARITY: begin
            if (sub == LAST) begin
              sub     <= '0;
              par_bit <= rxd;
              state   <= ST_STOP;
            end else begin
              sub <= sub + 1'b1;
            end
          end

          ST_STOP: begin
            if (sub == LAST) begin
              sub <= '0;
              if (rxd) begin
                char_valid <= 1'b1;
                char_data  <= shreg;
                char_perr  <= par_err;
                char_ferr  <= 1'b0;
                char_brk   <= 1'b0;
                state      <= ST_IDLE;
              end else if (zero_word) begin
                state <= ST_BRKWAIT;
              end else begin
                char_valid <= 1'b1;
                char_data  <= shreg;
                char_perr  <= par_err;
                char_ferr  <= 1'b1;
                char_brk   <= 1'b0;
                state      <= ST_CONFIRM;
              end
            end else begin
              sub <= sub + 1'b1;
            end
          end

          ST_CONFIRM: begin
            // second look at the low level taken as the next start bit
            if (!rxd) begin
              state   <= ST_DATA;
              sub     <= SUB_W'(1);
              bit_idx <= '0;
              shreg   <= '0;
              par_bit <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end

          ST_BRKWAIT: begin
            if (rxd) begin
              char_valid <= 1'b1;
              char_data  <= '0;
              char_perr  <= par_err;
              char_ferr  <= 1'b1;
              char_brk   <= 1'b0;
              state      <= ST_IDLE;
            end else if (sub == MID) begin
              char_valid <= 1'b1;
              char_data  <= '0;
              char_perr  <= 1'b0;
              char_ferr  <= 1'b0;
              char_brk   <= 1'b1;
              sub        <= '0;
              state      <= ST_REARM;
            end else begin
              sub <= sub + 1'b1;
            end
          end

          ST_REARM: begin
            if (!rxd)            sub   <= '0;
            else if (sub == MID) state <= ST_IDLE;
            else                 sub   <= sub + 1'b1;
          end

          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R10: strobe never lasts two clocks
  a_r10_strobe_single: assert property (@(posedge clk) disable iff (rst)
    char_valid |=> !char_valid);

  // R7: a break character carries an all-zero byte
  a_r7_brk_data_zero: assert property (@(posedge clk) disable iff (rst)
    (char_valid && char_brk) |-> (char_data == '0));

  // R7: break tag excludes the other tags
  a_r7_brk_excl: assert property (@(posedge clk) disable iff (rst)
    (char_valid && char_brk) |-> (!char_ferr && !char_perr));

  // R9: nothing is emitted while waiting for the line to re-arm
  a_r9_rearm_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REARM) |=> !char_valid);

  // R2: a start candidate that is high at its midpoint returns to idle
  a_r2_false_start: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && tick && sub == MID && rxd) |=> (state == ST_IDLE));

  // R3: in 5-bit mode the upper data bits stay zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (char_valid && cfg_data_bits == 2'b00) |-> (char_data[DATA_W-1:MIN_BITS] == '0));

endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk #(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_tick,
  input  logic              rxd,
  input  logic [1:0]        cfg_data_bits,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  output logic              char_valid,
  output logic [DATA_W-1:0] char_data,
  output logic              char_perr,
  output logic              char_ferr,
  output logic              char_brk
);

  logic              rxd_s;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              par_err;

  uart_rx_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rxd),
    .q   (rxd_s)
  );

  uart_rx_parity #(
    .DATA_W (DATA_W)
  ) u_parity (
    .data    (shreg),
    .par_bit (par_bit),
    .par_en  (cfg_par_en),
    .par_odd (cfg_par_odd),
    .par_err (par_err)
  );

  uart_rx_frame #(
    .OVERSAMPLE (OVERSAMPLE),
    .DATA_W     (DATA_W)
  ) u_frame (
    .clk           (clk),
    .rst           (rst),
    .tick          (sample_tick),
    .rxd           (rxd_s),
    .cfg_data_bits (cfg_data_bits),
    .cfg_par_en    (cfg_par_en),
    .par_err       (par_err),
    .shreg         (shreg),
    .par_bit       (par_bit),
    .char_valid    (char_valid),
    .char_data     (char_data),
    .char_perr     (char_perr),
    .char_ferr     (char_ferr),
    .char_brk      (char_brk)
  );

endmodule

// File: tb/uart_rx_brk_bench.sv
`timescale 1ns/1ps
module uart_rx_brk_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] cfg_data_bits = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [1:0] tcnt = '0;
  logic       sample_tick;
  logic       char_valid;
  logic [7:0] char_data;
  logic       char_perr, char_ferr, char_brk;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  logic [7:0] cap_data [64];
  logic       cap_perr [64];
  logic       cap_ferr [64];
  logic       cap_brk  [64];
  int         cap_cnt = 0;
  logic       prev_valid = 1'b0;
  logic       wide_seen = 1'b0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) tcnt <= '0;
    else     tcnt <= tcnt + 1'b1;
  end
  assign sample_tick = (tcnt == 2'd3);

  uart_rx_brk u_uart_rx_brk (
    .clk           (clk),
    .rst           (rst),
    .sample_tick   (sample_tick),
    .rxd           (rxd),
    .cfg_data_bits (cfg_data_bits),
    .cfg_par_en    (cfg_par_en),
    .cfg_par_odd   (cfg_par_odd),
    .char_valid    (char_valid),
    .char_data     (char_data),
    .char_perr     (char_perr),
    .char_ferr     (char_ferr),
    .char_brk      (char_brk)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (char_valid && prev_valid) wide_seen = 1'b1;
      if (char_valid && cap_cnt < 64) begin
        cap_data[cap_cnt] = char_data;
        cap_perr[cap_cnt] = char_perr;
        cap_ferr[cap_cnt] = char_ferr;
        cap_brk[cap_cnt]  = char_brk;
        cap_cnt = cap_cnt + 1;
      end
      prev_valid = char_valid;
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic lvl, input int ticks);
    @(negedge clk) rxd = lvl;
    repeat (ticks * 4 - 1) @(negedge clk);
  endtask

  task automatic configure(input int nbits, input bit pen, input bit podd);
    cfg_data_bits = 2'(nbits - 5);
    cfg_par_en    = pen;
    cfg_par_odd   = podd;
  endtask

  // stop_low == 0 gives a good 16-tick high stop; otherwise stop is low for stop_low ticks
  task automatic send_frame(input logic [7:0] d, input int nbits, input bit pen, input bit podd,
                            input bit bad_par, input int stop_low, input bit skip_start);
    logic p;
    p = 1'b0;
    if (!skip_start) drive(1'b0, 16);
    for (int i = 0; i < nbits; i++) begin
      drive(d[i], 16);
      p = p ^ d[i];
    end
    if (pen) drive(p ^ podd ^ bad_par, 16);
    if (stop_low == 0) drive(1'b1, 16);
    else               drive(1'b0, stop_low);
  endtask

  task automatic check_char(input string req, input int idx, input logic [7:0] d,
                            input bit pe, input bit fe, input bit bk);
    check_eq({req, " data"}, int'(cap_data[idx]), int'(d));
    check_eq({req, " perr"}, int'(cap_perr[idx]), int'(pe));
    check_eq({req, " ferr"}, int'(cap_ferr[idx]), int'(fe));
    check_eq({req, " brk"},  int'(cap_brk[idx]),  int'(bk));
  endtask

  task automatic t_reset;
    check_eq("R1 valid", int'(char_valid), 0);
    check_eq("R1 data",  int'(char_data), 0);
    check_eq("R1 tags",  int'({char_perr, char_ferr, char_brk}), 0);
  endtask

  task automatic t_basic_8n1;
    int b;
    configure(8, 0, 0);
    b = cap_cnt;
    send_frame(8'hA5, 8, 0, 0, 0, 0, 0);
    drive(1'b1, 20);
    check_eq("R3 count 8N1", cap_cnt - b, 1);
    check_char("R3 8N1", b, 8'hA5, 0, 0, 0);
  endtask

  task automatic t_five_even;
    int b;
    configure(5, 1, 0);
    b = cap_cnt;
    send_frame(8'hF5, 5, 1, 0, 0, 0, 0);
    drive(1'b1, 20);
    check_eq("R3 count 5E1", cap_cnt - b, 1);
    check_char("R3/R4 5E1", b, 8'h15, 0, 0, 0);
  endtask

  task automatic t_seven_odd_bad;
    int b;
    configure(7, 1, 1);
    b = cap_cnt;
    send_frame(8'h4B, 7, 1, 1, 1, 0, 0);
    drive(1'b1, 20);
    check_eq("R4 count 7O1 bad", cap_cnt - b, 1);
    check_char("R4 7O1 bad parity", b, 8'h4B, 1, 0, 0);
  endtask

  task automatic t_six_odd_good;
    int b;
    configure(6, 1, 1);
    b = cap_cnt;
    send_frame(8'h2A, 6, 1, 1, 0, 0, 0);
    drive(1'b1, 20);
    check_eq("R4 count 6O1", cap_cnt - b, 1);
    check_char("R4 6O1 good parity", b, 8'h2A, 0, 0, 0);
  endtask

  task automatic t_glitch;
    int b;
    configure(8, 0, 0);
    b = cap_cnt;
    drive(1'b0, 4);
    drive(1'b1, 30);
    check_eq("R2 short low rejected", cap_cnt - b, 0);
    send_frame(8'h33, 8, 0, 0, 0, 0, 0);
    drive(1'b1, 20);
    check_eq("R2 count after glitch", cap_cnt - b, 1);
    check_char("R2 after glitch", b, 8'h33, 0, 0, 0);
  endtask

  task automatic t_frame_resync;
    int b;
    configure(8, 0, 0);
    b = cap_cnt;
    send_frame(8'h3C, 8, 0, 0, 0, 16, 0);
    send_frame(8'h81, 8, 0, 0, 0, 0, 1);
    drive(1'b1, 20);
    check_eq("R6 count resync", cap_cnt - b, 2);
    check_char("R5 framing char", b, 8'h3C, 0, 1, 0);
    check_char("R6 resync char", b + 1, 8'h81, 0, 0, 0);
  endtask

  task automatic t_zero_good;
    int b;
    configure(8, 0, 0);
    b = cap_cnt;
    send_frame(8'h00, 8, 0, 0, 0, 0, 0);
    drive(1'b1, 20);
    check_eq("R11 count zero", cap_cnt - b, 1);
    check_char("R11 zero char", b, 8'h00, 0, 0, 0);
  endtask

  task automatic t_short_zero;
    int b;
    configure(8, 0, 0);
    b = cap_cnt;
    send_frame(8'h00, 8, 0, 0, 0, 10, 0);
    drive(1'b1, 20);
    check_eq("R8 count short zero", cap_cnt - b, 1);
    check_char("R8 short zero", b, 8'h00, 0, 1, 0);
  endtask

  task automatic t_break;
    int b;
    configure(8, 1, 0);
    b = cap_cnt;
    drive(1'b0, 400);
    drive(1'b1, 20);
    check_eq("R7 one break char", cap_cnt - b, 1);
    check_char("R7 break", b, 8'h00, 0, 0, 1);
    send_frame(8'h6E, 8, 1, 0, 0, 0, 0);
    drive(1'b1, 20);
    check_eq("R7 count after break", cap_cnt - b, 2);
    check_char("R7 after break", b + 1, 8'h6E, 0, 0, 0);
  endtask

  task automatic t_rearm;
    int b;
    configure(8, 0, 0);
    b = cap_cnt;
    drive(1'b0, 200);
    drive(1'b1, 4);
    drive(1'b0, 16);
    drive(1'b1, 30);
    check_eq("R9 only break char", cap_cnt - b, 1);
    check_eq("R9 break tag", int'(cap_brk[b]), 1);
    send_frame(8'h5A, 8, 0, 0, 0, 0, 0);
    drive(1'b1, 20);
    check_eq("R9 count after rearm", cap_cnt - b, 2);
    check_char("R9 after rearm", b + 1, 8'h5A, 0, 0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    drive(1'b1, 20);
    t_basic_8n1();
    t_five_even();
    t_seven_odd_bad();
    t_six_odd_good();
    t_glitch();
    t_frame_resync();
    t_zero_good();
    t_short_zero();
    t_break();
    t_rearm();
    check_eq("R10 strobe one clock", int'(wide_seen), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule